// File: doc/BRIEF.md
# External Bus Master Controller

This block runs one transaction at a time on a shared 32-bit address/data bus for an internal requester. The requester presents an address, write data, a transfer size, a direction, a burst flag and a flag that marks the access as chip-select controlled. It samples these in a cycle where `req_valid` is high and the block is idle. The block then raises the transfer-start strobe for one clock, together with the direction line and the address. After that it moves into the data phase, which has one beat, or four beats for a burst.

Two termination paths exist. A chip-select access ends each beat on an internal wait count and announces the acknowledge itself. Any other access waits for the slave's transfer acknowledge. Either kind of access may end early on a transfer error acknowledge. Output enable for external memories is given only on chip-select reads. The address can also be multiplexed onto the data bus during the address phase. A 16-bit port mode uses only one selectable half of the bus. Narrow reads are extracted from the selected byte lanes, and the block ignores all other lanes.

Top module: `ext_bus_master`

## Requirements
- R1: The block accepts a request when `req_valid` is high and `busy` is low. `bus_ts` is then high for exactly the one following cycle, and `bus_addr` carries the request address in that cycle.
- R2: `bus_rd_wr` is 1 for a read and 0 for a write. It takes its value in the `bus_ts` cycle and holds that value until the transaction ends.
- R3: `bus_oe` is high only during the data phase of a chip-select read. It rises in the cycle after `bus_ts` and stays high until the last beat terminates. It is never high for writes or for externally terminated accesses.
- R4: When `cfg_mux_en` is 1, `bus_ad_oe` is high in the `bus_ts` cycle and `bus_ad_out` carries the address. When `cfg_mux_en` is 0, the bus is released in that cycle.
- R5: `bus_ad_oe` is high during every write data cycle and low during every read data cycle.
- R6: On a chip-select access, each beat lasts `cfg_wait`+1 data cycles. `bus_ack_drive` is high in the final cycle of a beat. The block ignores `bus_ta_in` throughout the access.
- R7: On an external access, each read beat ends in the cycle where `bus_ta_in` is high. A burst has four beats, and each beat needs its own acknowledge.
- R8: A write, including a four-beat burst, completes on one acknowledge. On chip-select writes, `bus_ack_drive` is high only at the end of the last beat. On external writes, each non-final beat lasts one cycle and the final beat waits for `bus_ta_in`.
- R9: Size codes are 0 for byte, 1 for half-word and 2 for word. Write data is right-justified in each 32-bit beat word. On the 32-bit port, a byte goes to bits 8*addr[1:0] and up, a half-word goes to bits 16*addr[1] and up, and a word or burst beat uses all 32 bits. Lanes that are not selected are driven as 0.
- R10: When `cfg_port16` is 1, only bits [31:16] are used if `cfg_hi_half` is 1, and only bits [15:0] otherwise. A byte sits at offset 8*addr[0] within that half. Words and burst beats are carried as 16-bit half-words.
- R11: On a read, `rd_data` holds the selected lanes shifted down to bit 0 and zero-extended. Unselected lanes have no effect on it.
- R12: `bus_tea_in` high in any data cycle ends the transaction. One cycle later `xfer_done` and `xfer_err` are both high and `busy` is low.
- R13: `xfer_done` pulses for one cycle, with `xfer_err` low, one cycle after the final beat terminates normally. `rd_valid` pulses one cycle after each read beat terminates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Start a transaction (accepted while idle) |
| req_addr | input | 32 | Transaction address |
| req_wdata | input | 128 | Write data, beat k in bits [32k+31:32k] |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word |
| req_write | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | Four-beat burst |
| req_cs | input | 1 | Chip-select controlled (internal termination) |
| cfg_wait | input | 4 | Wait cycles per chip-select beat |
| cfg_mux_en | input | 1 | Address driven on data bus in address phase |
| cfg_port16 | input | 1 | 16-bit port mode |
| cfg_hi_half | input | 1 | In 16-bit mode: 1 uses bits [31:16], 0 uses [15:0] |
| busy | output | 1 | Transaction in progress |
| xfer_done | output | 1 | One-cycle completion pulse |
| xfer_err | output | 1 | Error status, valid with xfer_done |
| rd_valid | output | 1 | Read beat data valid pulse |
| rd_data | output | 32 | Extracted read data |
| bus_ts | output | 1 | Transfer-start strobe |
| bus_rd_wr | output | 1 | 1 read, 0 write |
| bus_oe | output | 1 | Output enable for external memory |
| bus_addr | output | 32 | Address lines |
| bus_ad_out | output | 32 | Address/data bus drive value |
| bus_ad_oe | output | 1 | Tristate enable for bus_ad_out |
| bus_ad_in | input | 32 | Address/data bus sampled value |
| bus_ta_in | input | 1 | Transfer acknowledge from slave |
| bus_tea_in | input | 1 | Transfer error acknowledge |
| bus_ack_drive | output | 1 | Internally generated acknowledge |

## Verification
The embedded assertions check the following on every clock: the start strobe lasts one cycle, the direction line stays steady through the data phase, output enable never appears on writes or non-chip-select accesses and follows the strobe on chip-select reads, the bus is released whenever output enable is given, the internal acknowledge appears only on chip-select accesses, an error acknowledge ends the access with error status, and the completion pulse lasts one cycle. Other behaviour depends on the values and timing of a particular transaction, so only the bench's scenarios can show it. This covers lane placement and extraction for each size, address and port half, the number of cycles per beat under each wait count or slave latency, a single acknowledge on burst writes, four acknowledges on burst reads, and early slave acknowledges having no effect on chip-select accesses.

// File: rtl/ext_bus_master.sv
module ext_bus_master #(
  parameter int AW          = 32,
  parameter int WAIT_W      = 4,
  parameter int BURST_BEATS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [AW-1:0]               req_addr,
  input  logic [32*BURST_BEATS-1:0]   req_wdata,
  input  logic [1:0]                  req_size,
  input  logic                        req_write,
  input  logic                        req_burst,
  input  logic                        req_cs,
  input  logic [WAIT_W-1:0]           cfg_wait,
  input  logic                        cfg_mux_en,
  input  logic                        cfg_port16,
  input  logic                        cfg_hi_half,
  output logic                        busy,
  output logic                        xfer_done,
  output logic                        xfer_err,
  output logic                        rd_valid,
  output logic [31:0]                 rd_data,
  output logic                        bus_ts,
  output logic                        bus_rd_wr,
  output logic                        bus_oe,
  output logic [AW-1:0]               bus_addr,
  output logic [31:0]                 bus_ad_out,
  output logic                        bus_ad_oe,
  input  logic [31:0]                 bus_ad_in,
  input  logic                        bus_ta_in,
  input  logic                        bus_tea_in,
  output logic                        bus_ack_drive
);
  localparam int DW     = 32;
  localparam int BEAT_W = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA} state_t;

  state_t                    st;
  logic [AW-1:0]             addr_q;
  logic [DW*BURST_BEATS-1:0] wdat_q;
  logic [1:0]                size_q;
  logic                      wr_q, burst_q, cs_q, mux_q, p16_q, hi_q;
  logic [WAIT_W-1:0]         wait_q, cnt_q;
  logic [BEAT_W-1:0]         beat_q;
  logic                      done_q, err_q, rvalid_q;
  logic [DW-1:0]             rdata_q;

  logic          in_data, last_beat, cnt_zero, beat_end, abort;
  logic [1:0]    eff;
  logic [4:0]    shamt;
  logic [DW-1:0] lmask, cur_wd, wr_place, rd_extract;

  assign in_data   = (st == S_DATA);
  assign cnt_zero  = (cnt_q == '0);
  assign last_beat = burst_q ? (beat_q == BEAT_W'(BURST_BEATS-1)) : (beat_q == '0);
  assign abort     = in_data && bus_tea_in;
  assign beat_end  = in_data && (cs_q ? cnt_zero : ((wr_q && !last_beat) ? 1'b1 : bus_ta_in));

  assign eff = burst_q ? (p16_q ? 2'd1 : 2'd2)
             : ((p16_q && size_q[1]) ? 2'd1 : size_q);

  always_comb begin
    if (p16_q)
      shamt = (hi_q ? 5'd16 : 5'd0) + ((eff == 2'd0 && addr_q[0]) ? 5'd8 : 5'd0);
    else begin
      case (eff)
        2'd0:    shamt = {addr_q[1:0], 3'b000};
        2'd1:    shamt = {addr_q[1], 4'b0000};
        default: shamt = 5'd0;
      endcase
    end
    case (eff)
      2'd0:    lmask = 32'h0000_00FF;
      2'd1:    lmask = 32'h0000_FFFF;
      default: lmask = 32'hFFFF_FFFF;
    endcase
  end

  assign cur_wd     = wdat_q[DW*int'(beat_q) +: DW];
  assign wr_place   = (cur_wd & lmask) << shamt;
  assign rd_extract = (bus_ad_in >> shamt) & lmask;

  assign busy          = (st != S_IDLE);
  assign xfer_done     = done_q;
  assign xfer_err      = err_q;
  assign rd_valid      = rvalid_q;
  assign rd_data       = rdata_q;
  assign bus_ts        = (st == S_ADDR);
  assign bus_rd_wr     = busy ? !wr_q : 1'b1;
  assign bus_addr      = addr_q;
  assign bus_oe        = in_data && !wr_q && cs_q;
  assign bus_ad_oe     = (bus_ts && mux_q) || (in_data && wr_q);
  assign bus_ad_out    = bus_ts ? DW'(addr_q) : (in_data && wr_q) ? wr_place : '0;
  assign bus_ack_drive = in_data && cs_q && cnt_zero && (!wr_q || last_beat) && !bus_tea_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      addr_q <= '0; wdat_q <= '0; size_q <= '0;
      wr_q <= 1'b0; burst_q <= 1'b0; cs_q <= 1'b0;
      mux_q <= 1'b0; p16_q <= 1'b0; hi_q <= 1'b0;
      wait_q <= '0; cnt_q <= '0; beat_q <= '0;
      done_q <= 1'b0; err_q <= 1'b0; rvalid_q <= 1'b0; rdata_q <= '0;
    end else begin
      done_q   <= 1'b0;
      rvalid_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          st <= S_ADDR;
          addr_q <= req_addr; wdat_q <= req_wdata; size_q <= req_size;
          wr_q <= req_write; burst_q <= req_burst; cs_q <= req_cs;
          mux_q <= cfg_mux_en; p16_q <= cfg_port16; hi_q <= cfg_hi_half;
          wait_q <= cfg_wait; err_q <= 1'b0;
        end
        S_ADDR: begin
          st <= S_DATA;
          beat_q <= '0;
          cnt_q <= wait_q;
        end
        S_DATA: begin
          if (abort) begin
            st <= S_IDLE; done_q <= 1'b1; err_q <= 1'b1;
          end else if (beat_end) begin
            if (!wr_q) begin
              rvalid_q <= 1'b1;
              rdata_q  <= rd_extract;
            end
            if (last_beat) begin
              st <= S_IDLE; done_q <= 1'b1;
            end else begin
              beat_q <= beat_q + 1'b1;
              cnt_q  <= wait_q;
            end
          end else if (cs_q && !cnt_zero) begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  ts_single_chk: assert property (@(posedge clk) disable iff (!rst_n) bus_ts |=> !bus_ts);
  // R2
  rdwr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n) in_data |-> $stable(bus_rd_wr));
  // R3
  oe_cs_read_chk: assert property (@(posedge clk) disable iff (!rst_n) bus_oe |-> (bus_rd_wr && cs_q));
  // R3
  oe_follows_ts_chk: assert property (@(posedge clk) disable iff (!rst_n) (bus_ts && bus_rd_wr && cs_q) |=> bus_oe);
  // R5
  bus_free_on_oe_chk: assert property (@(posedge clk) disable iff (!rst_n) bus_oe |-> !bus_ad_oe);
  // R6
  ack_cs_only_chk: assert property (@(posedge clk) disable iff (!rst_n) bus_ack_drive |-> (cs_q && busy));
  // R12
  tea_ends_chk: assert property (@(posedge clk) disable iff (!rst_n) (in_data && bus_tea_in) |=> (xfer_done && xfer_err && !busy));
  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) xfer_done |=> !xfer_done);
endmodule

// File: tb/sim_ext_bus_master.sv
module sim_ext_bus_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_burst = 0, req_cs = 0;
  logic [31:0] req_addr = '0;
  logic [127:0] req_wdata = '0;
  logic [1:0] req_size = '0;
  logic [3:0] cfg_wait = '0;
  logic cfg_mux_en = 0, cfg_port16 = 0, cfg_hi_half = 0;
  logic busy, xfer_done, xfer_err, rd_valid, bus_ts, bus_rd_wr, bus_oe, bus_ad_oe, bus_ack_drive;
  logic [31:0] rd_data, bus_addr, bus_ad_out;
  logic [31:0] bus_ad_in = '0;
  logic bus_ta_in = 0, bus_tea_in = 0;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  ext_bus_master u0 (.*);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // cs, wr, burst, size, addr, mux, p16, hi, wait, slave latency, error cycle (-1 none)
  task automatic run(bit cs, bit wr, bit burst, int size, logic [31:0] addr, bit mux,
                     bit p16, bit hi, int waitc, int lat, int tea_at);
    int nb = burst ? 4 : 1;
    int eff, sh, dcyc = 0;
    logic [31:0] m, pend_rd = '0;
    logic [127:0] wd;
    bit pend = 0, aborted = 0;
    eff = burst ? (p16 ? 1 : 2) : ((p16 && size == 2) ? 1 : size);
    m = (eff == 0) ? 32'hFF : (eff == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    if (p16) sh = (hi ? 16 : 0) + ((eff == 0) ? 8 * int'(addr[0]) : 0);
    else sh = (eff == 0) ? 8 * int'(addr[1:0]) : (eff == 1) ? 16 * int'(addr[1]) : 0;
    wd = {$urandom, $urandom, $urandom, $urandom};
    @(negedge clk);
    req_valid = 1; req_cs = cs; req_write = wr; req_burst = burst; req_size = 2'(size);
    req_addr = addr; req_wdata = wd; cfg_mux_en = mux; cfg_port16 = p16; cfg_hi_half = hi;
    cfg_wait = 4'(waitc);
    #1 chk("R1", "idle before", 32'(busy), 0);
    @(negedge clk);
    req_valid = 0;
    #1;
    chk("R1", "ts", 32'(bus_ts), 1);
    chk("R1", "addr", bus_addr, addr);
    chk("R2", "rd_wr at ts", 32'(bus_rd_wr), 32'(!wr));
    chk("R4", "ad_oe at ts", 32'(bus_ad_oe), 32'(mux));
    if (mux) chk("R4", "addr on bus", bus_ad_out, addr);
    chk("R3", "oe at ts", 32'(bus_oe), 0);
    for (int b = 0; b < nb; b++) begin
      int len = cs ? waitc + 1 : (wr && b < nb - 1) ? 1 : lat + 1;
      for (int c = 0; c < len; c++) begin
        logic [31:0] wexp;
        @(negedge clk);
        if (pend) begin
          chk("R13", "rd_valid", 32'(rd_valid), 1);
          chk("R11", "rd_data", rd_data, pend_rd);
          pend = 0;
        end else chk("R13", "no rd_valid", 32'(rd_valid), 0);
        bus_ad_in = $urandom;
        bus_tea_in = (dcyc == tea_at);
        if (cs) bus_ta_in = (c == 0 && len > 1);
        else bus_ta_in = (c == len - 1) && !(wr && b < nb - 1);
        #1;
        chk("R1", "ts low in data", 32'(bus_ts), 0);
        chk("R2", "rd_wr held", 32'(bus_rd_wr), 32'(!wr));
        chk("R3", "oe", 32'(bus_oe), 32'(!wr && cs));
        chk("R5", "ad_oe", 32'(bus_ad_oe), 32'(wr));
        if (wr) begin
          wexp = (wd[32*b +: 32] & m) << sh;
          chk(p16 ? "R10" : "R9", "write lanes", bus_ad_out, wexp);
        end
        chk(cs ? "R6" : "R8", "ack_drive", 32'(bus_ack_drive),
            32'(cs && c == len - 1 && (!wr || b == nb - 1) && !bus_tea_in));
        if (bus_tea_in) begin aborted = 1; break; end
        if (c == len - 1 && !wr) begin
          pend = 1;
          pend_rd = (bus_ad_in >> sh) & m;
        end
        dcyc++;
      end
      if (aborted) break;
    end
    @(negedge clk);
    bus_ta_in = 0; bus_tea_in = 0;
    #1;
    chk(aborted ? "R12" : "R13", "done", 32'(xfer_done), 1);
    chk(aborted ? "R12" : "R13", "err", 32'(xfer_err), 32'(aborted));
    chk(cs ? "R6" : "R7", "idle after end", 32'(busy), 0);
    chk("R13", "last rd_valid", 32'(rd_valid), 32'(pend));
    if (pend) chk(p16 ? "R10" : "R11", "last rd_data", rd_data, pend_rd);
    @(negedge clk);
    #1 chk("R13", "done pulse", 32'(xfer_done), 0);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog act=%0d exp=done", tests);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1", "reset busy", 32'(busy), 0);
    chk("R1", "reset ts", 32'(bus_ts), 0);
    chk("R3", "reset oe", 32'(bus_oe), 0);
    chk("R5", "reset ad_oe", 32'(bus_ad_oe), 0);
    chk("R13", "reset done", 32'(xfer_done), 0);
    run(1, 0, 0, 2, 32'h1000_0040, 0, 0, 0, 2, 0, -1);  // R6 cs word read, wait 2
    run(1, 1, 0, 1, 32'h2000_0002, 1, 0, 0, 0, 0, -1);  // R4 R9 cs half write, mux
    run(1, 0, 1, 2, 32'h3000_0000, 0, 0, 0, 1, 0, -1);  // R6 cs burst read
    run(1, 1, 1, 2, 32'h3000_0100, 1, 0, 0, 1, 0, -1);  // R8 cs burst write
    run(0, 0, 0, 0, 32'h4000_0003, 0, 0, 0, 0, 2, -1);  // R7 R11 ext byte read
    run(0, 0, 1, 2, 32'h5000_0000, 1, 1, 1, 0, 1, -1);  // R7 R10 ext burst read upper half
    run(0, 1, 1, 2, 32'h5000_0010, 0, 0, 0, 0, 3, -1);  // R8 ext burst write
    run(0, 0, 0, 2, 32'h6000_0000, 0, 0, 0, 0, 4, 2);   // R12 ext read error
    run(1, 0, 1, 2, 32'h6000_0020, 0, 0, 0, 3, 0, 6);   // R12 cs burst read error
    run(0, 0, 0, 0, 32'h7000_0001, 0, 1, 0, 0, 1, -1);  // R10 port16 low byte read
    run(0, 1, 0, 0, 32'h7000_0001, 0, 1, 1, 0, 0, -1);  // R10 port16 high byte write
    run(1, 1, 0, 0, 32'h7000_0002, 0, 0, 0, 15, 0, -1); // R6 R9 max wait byte write
    run(0, 0, 0, 1, 32'h7000_0002, 1, 0, 0, 0, 0, -1);  // R11 half read upper lanes
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule